// File: doc/BRIEF.md
# Memory-Reference Instruction Sequencer

This block carries out the memory side of the six memory-reference instructions of a 12-bit accumulator machine. It accepts one instruction word at a time, together with the address that instruction was fetched from and the current accumulator and link. It works out the operand address, follows a pointer when the instruction asks for indirection, and bumps that pointer in place when the pointer sits in the auto-index window. It then performs the load, the store, or both, that the opcode calls for. When the instruction is finished it presents the new accumulator, link and program counter, and pulses a completion strobe for one cycle.

All memory traffic goes through a single request channel and a single response channel, each with a valid/ready handshake. Every access, reads and writes alike, returns a response. The block keeps at most one access outstanding. The two opcodes outside the memory-reference group (values 6 and 7) are not executed: the block only steps the program counter for them.

Top module: `mri_seq`

## Requirements
- R1: Opcodes 6 and 7 (instruction bits 11:9) make no memory access, leave the accumulator and link unchanged, and complete with next PC equal to PC+1.
- R2: The direct address is instruction bits 6:0. When instruction bit 7 is set, the page bits 11:7 of PC+1 are placed above them. When bit 7 is clear, the upper bits are zero.
- R3: When instruction bit 8 is set, the block first reads the word at the direct address. That word becomes the operand address.
- R4: For indirect AND, TAD, ISZ and DCA (opcodes 0 to 3) whose direct address lies in 010 to 017, the block writes the pointer plus one, modulo 4096, back to the direct address. It does this right after the pointer read, and the incremented value becomes the operand address.
- R5: JMS (4) and JMP (5) never write back their pointer, even when the direct address lies in 010 to 017.
- R6: AND (0) reads the operand and sets the accumulator to the bitwise AND of the accumulator and the operand.
- R7: TAD (1) reads the operand and adds it to the 13-bit value {link, accumulator}. Bit 12 of the sum goes to the link and bits 11:0 go to the accumulator.
- R8: ISZ (2) reads the operand and stores the operand plus one, modulo 4096, to the same address. If the stored value is zero, the next PC is PC+2; otherwise it is PC+1.
- R9: DCA (3) stores the accumulator at the operand address and then clears the accumulator.
- R10: JMS stores PC+1 at the operand address and continues at the operand address plus one. JMP makes no data access and continues at the operand address.
- R11: Accesses are issued in this order: pointer read, pointer write-back, operand read, operand store. A new request is never raised while an earlier one awaits its response. A request that is not yet accepted holds its address, direction and data steady.
- R12: All PC arithmetic wraps within 12 bits. The completion strobe is high for exactly one cycle, and no new instruction is accepted while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle and able to take an instruction |
| in_instr | input | 12 | Instruction word |
| in_pc | input | 12 | Address the instruction was fetched from |
| in_acc | input | 12 | Accumulator before the instruction |
| in_link | input | 1 | Link before the instruction |
| done | output | 1 | One-cycle completion strobe |
| next_pc | output | 12 | Program counter after the instruction, valid with done |
| acc_out | output | 12 | Accumulator after the instruction, valid with done |
| link_out | output | 1 | Link after the instruction, valid with done |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 12 | Word address |
| mem_req_wdata | output | 12 | Write data |
| mem_rsp_valid | input | 1 | Memory response offered |
| mem_rsp_ready | output | 1 | Block takes the response |
| mem_rsp_rdata | input | 12 | Read data, or don't care for a write |

## Verification
The bench goes after the auto-index corner cases. One is a pointer of 07777, which must wrap the operand address to 0. Another is a pointer that increments onto its own location, so the operand read must return the value just written. A design that used the old pointer, or that read before writing, would log an access at the wrong address or with the wrong data. Other directed cases are a TAD with both link and accumulator carrying, an ISZ of 07777 that must skip, a JMP through a location in the auto-index window that must not write, and current-page addressing with PC 07777, whose increment wraps to page zero. Random instructions run against a memory that stalls its ready and delays its responses by random amounts. A design that dropped a request while stalled, or issued a second one too early, would log a broken access sequence.

// File: rtl/mri_pkg.sv
package mri_pkg;
  localparam int WORD_W   = 12;
  localparam int OFF_W    = 7;
  localparam int OP_W     = 3;
  localparam int WIN_LO_W = 3;
  localparam int WIN_IDX  = 1;
  localparam int PAGE_BIT = OFF_W;
  localparam int IND_BIT  = OFF_W + 1;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0, OP_TAD = 3'd1, OP_ISZ = 3'd2, OP_DCA = 3'd3,
    OP_JMS = 3'd4, OP_JMP = 3'd5, OP_IOX = 3'd6, OP_MSC = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PTR_RD, S_PTR_WB, S_OPD_RD, S_OPD_WR, S_FIN
  } state_e;

  function automatic word_t wrap_inc(word_t w);
    return w + word_t'(1);
  endfunction

  function automatic word_t form_addr(word_t instr, word_t pc_next);
    word_t base;
    base = instr[PAGE_BIT] ? {pc_next[WORD_W-1:OFF_W], {OFF_W{1'b0}}} : '0;
    return base | {{(WORD_W-OFF_W){1'b0}}, instr[OFF_W-1:0]};
  endfunction

  function automatic logic in_bump_window(word_t a);
    return (a >> WIN_LO_W) == word_t'(WIN_IDX);
  endfunction

  function automatic logic [WORD_W:0] add_with_link(logic lk, word_t acc, word_t opd);
    return {lk, acc} + {1'b0, opd};
  endfunction
endpackage

// File: rtl/mri_decode.sv
module mri_decode
  import mri_pkg::*;
(
  input  word_t instr,
  input  word_t pc,
  output op_e   op,
  output logic  is_mem,
  output logic  indirect,
  output logic  needs_load,
  output logic  needs_store,
  output logic  bump_ptr,
  output word_t pc_next,
  output word_t addr0
);
  logic is_jump;

  always_comb begin
    op          = op_e'(instr[WORD_W-1 -: OP_W]);
    pc_next     = wrap_inc(pc);
    addr0       = form_addr(instr, pc_next);
    is_mem      = (op != OP_IOX) && (op != OP_MSC);
    is_jump     = (op == OP_JMS) || (op == OP_JMP);
    indirect    = is_mem && instr[IND_BIT];
    needs_load  = (op == OP_AND) || (op == OP_TAD) || (op == OP_ISZ);
    needs_store = (op == OP_ISZ) || (op == OP_DCA) || (op == OP_JMS);
    bump_ptr    = indirect && !is_jump && in_bump_window(addr0);
  end
endmodule

// File: rtl/mri_alu.sv
module mri_alu
  import mri_pkg::*;
(
  input  op_e   op,
  input  word_t acc,
  input  logic  link,
  input  word_t rdata,
  input  word_t pc_next,
  input  word_t ea,
  input  word_t isz_val,
  output word_t ld_acc,
  output logic  ld_link,
  output word_t isz_next,
  output word_t st_data,
  output word_t npc
);
  logic [WORD_W:0] sum;

  always_comb begin
    sum      = add_with_link(link, acc, rdata);
    ld_acc   = acc;
    ld_link  = link;
    if (op == OP_AND) ld_acc = acc & rdata;
    if (op == OP_TAD) begin
      ld_acc  = sum[WORD_W-1:0];
      ld_link = sum[WORD_W];
    end
    isz_next = wrap_inc(rdata);
    case (op)
      OP_ISZ:  st_data = isz_val;
      OP_DCA:  st_data = acc;
      default: st_data = pc_next;
    endcase
    case (op)
      OP_JMP:  npc = ea;
      OP_JMS:  npc = wrap_inc(ea);
      OP_ISZ:  npc = (isz_val == '0) ? wrap_inc(pc_next) : pc_next;
      default: npc = pc_next;
    endcase
  end
endmodule

// File: rtl/mri_seq.sv
module mri_seq
  import mri_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_instr,
  input  logic [WORD_W-1:0] in_pc,
  input  logic [WORD_W-1:0] in_acc,
  input  logic              in_link,
  output logic              done,
  output logic [WORD_W-1:0] next_pc,
  output logic [WORD_W-1:0] acc_out,
  output logic              link_out,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [WORD_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [WORD_W-1:0] mem_rsp_rdata
);
  state_e st;
  logic   wait_q;
  word_t  instr_q, pc_q, acc_q, addr0_q, ea_q, data_q;
  logic   link_q;

  logic   idle;
  word_t  dec_instr, dec_pc, dec_pc_next, dec_addr0;
  op_e    dec_op;
  logic   dec_mem, dec_ind, dec_load, dec_store, dec_bump;
  state_e first_exec;

  word_t  alu_acc, alu_isz, alu_st, alu_npc;
  logic   alu_link;

  // Named events for the checker
  logic   req_fire, rsp_fire, mem_phase, autoinc_phase;

  assign idle      = (st == S_IDLE);
  assign dec_instr = idle ? in_instr : instr_q;
  assign dec_pc    = idle ? in_pc : pc_q;

  mri_decode u_dec (
    .instr(dec_instr), .pc(dec_pc), .op(dec_op), .is_mem(dec_mem),
    .indirect(dec_ind), .needs_load(dec_load), .needs_store(dec_store),
    .bump_ptr(dec_bump), .pc_next(dec_pc_next), .addr0(dec_addr0)
  );

  mri_alu u_alu (
    .op(dec_op), .acc(acc_q), .link(link_q), .rdata(mem_rsp_rdata),
    .pc_next(dec_pc_next), .ea(ea_q), .isz_val(data_q),
    .ld_acc(alu_acc), .ld_link(alu_link), .isz_next(alu_isz),
    .st_data(alu_st), .npc(alu_npc)
  );

  always_comb begin
    if (dec_load)       first_exec = S_OPD_RD;
    else if (dec_store) first_exec = S_OPD_WR;
    else                first_exec = S_FIN;
  end

  assign mem_phase     = (st == S_PTR_RD) || (st == S_PTR_WB) ||
                         (st == S_OPD_RD) || (st == S_OPD_WR);
  assign autoinc_phase = (st == S_PTR_WB);
  assign mem_req_valid = mem_phase && !wait_q;
  assign mem_rsp_ready = wait_q;
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign rsp_fire      = mem_rsp_valid && mem_rsp_ready;
  assign mem_req_write = (st == S_PTR_WB) || (st == S_OPD_WR);
  assign mem_req_addr  = ((st == S_PTR_RD) || (st == S_PTR_WB)) ? addr0_q : ea_q;
  assign mem_req_wdata = (st == S_PTR_WB) ? ea_q : alu_st;

  assign in_ready = idle;
  assign done     = (st == S_FIN);
  assign next_pc  = alu_npc;
  assign acc_out  = acc_q;
  assign link_out = link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wait_q  <= 1'b0;
      instr_q <= '0;
      pc_q    <= '0;
      acc_q   <= '0;
      link_q  <= 1'b0;
      addr0_q <= '0;
      ea_q    <= '0;
      data_q  <= '0;
    end else begin
      if (req_fire) wait_q <= 1'b1;
      if (rsp_fire) wait_q <= 1'b0;
      case (st)
        S_IDLE: if (in_valid) begin
          instr_q <= in_instr;
          pc_q    <= in_pc;
          acc_q   <= in_acc;
          link_q  <= in_link;
          addr0_q <= dec_addr0;
          ea_q    <= dec_addr0;
          data_q  <= '0;
          if (!dec_mem)     st <= S_FIN;
          else if (dec_ind) st <= S_PTR_RD;
          else              st <= first_exec;
        end
        S_PTR_RD: if (rsp_fire) begin
          if (dec_bump) begin
            ea_q <= wrap_inc(mem_rsp_rdata);
            st   <= S_PTR_WB;
          end else begin
            ea_q <= mem_rsp_rdata;
            st   <= first_exec;
          end
        end
        S_PTR_WB: if (rsp_fire) st <= first_exec;
        S_OPD_RD: if (rsp_fire) begin
          acc_q  <= alu_acc;
          link_q <= alu_link;
          if (dec_op == OP_ISZ) begin
            data_q <= alu_isz;
            st     <= S_OPD_WR;
          end else begin
            st <= S_FIN;
          end
        end
        S_OPD_WR: if (rsp_fire) begin
          if (dec_op == OP_DCA) acc_q <= '0;
          st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mri_seq_chk.sv
module mri_seq_chk
  import mri_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [WORD_W-1:0] mem_req_addr,
  input logic [WORD_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic              autoinc_phase
);
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
    else if (mem_rsp_valid && mem_rsp_ready) outstanding <= 1'b0;
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !mem_req_valid);

  a_r11_rsp_only_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> outstanding);

  a_r4_bump_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    autoinc_phase && mem_req_valid |-> mem_req_write
      && ((mem_req_addr >> WIN_LO_W) == WORD_W'(WIN_IDX)));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_no_accept_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready && !mem_req_valid);
endmodule

bind mri_seq mri_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .done(done),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_ready(mem_rsp_ready), .autoinc_phase(autoinc_phase)
);

// File: tb/mri_seq_tb.sv
module mri_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_instr = '0, in_pc = '0, in_acc = '0;
  logic        in_link = 1'b0;
  logic        done;
  logic [11:0] next_pc, acc_out;
  logic        link_out;
  logic        mem_req_valid, mem_req_write, mem_rsp_ready;
  logic        mem_req_ready = 1'b0;
  logic [11:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [11:0] mem_rsp_rdata = '0;

  always #10 clk = ~clk;

  mri_seq u_dut (.*);

  int nchk = 0, nfail = 0, cycles = 0;

  bit [11:0] mem [4096];
  bit [11:0] exp_mem [4096];

  // Access log from the memory model and the expected list
  bit        lg_w [8];
  bit [11:0] lg_a [8], lg_d [8];
  int        lg_n;
  bit        ex_w [8];
  bit [11:0] ex_a [8], ex_d [8];
  int        ex_n;
  bit [11:0] x_acc, x_npc;
  bit        x_link;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0o expected=%0o", tag, act, expv);
    end
  endtask

  // Memory responder: capture handshakes at the edge, act at the falling edge
  bit        s_req, s_rsp, s_w;
  bit [11:0] s_a, s_d;
  bit        pend;
  int        lat;
  bit [11:0] pend_d;

  always @(posedge clk) begin
    cycles++;
    s_req <= mem_req_valid && mem_req_ready;
    s_rsp <= mem_rsp_valid && mem_rsp_ready;
    s_w   <= mem_req_write;
    s_a   <= mem_req_addr;
    s_d   <= mem_req_wdata;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (s_rsp) mem_rsp_valid = 1'b0;
      if (s_req) begin
        if (lg_n < 8) begin
          lg_w[lg_n] = s_w;
          lg_a[lg_n] = s_a;
          lg_d[lg_n] = s_w ? s_d : mem[s_a];
        end
        lg_n++;
        if (s_w) mem[s_a] = s_d;
        pend_d = mem[s_a];
        pend = 1'b1;
        lat = int'($urandom % 3);
        mem_req_ready = 1'b0;
      end
      if (pend && !mem_rsp_valid) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = pend_d;
          pend = 1'b0;
        end else lat--;
      end
      if (!pend && !mem_rsp_valid) mem_req_ready = (($urandom % 4) != 0);
    end
  end

  task automatic push(input bit w, input bit [11:0] a, input bit [11:0] d);
    ex_w[ex_n] = w; ex_a[ex_n] = a; ex_d[ex_n] = d; ex_n++;
  endtask

  // Reference model written from the requirements
  task automatic model(input bit [11:0] ins, input bit [11:0] pc,
                       input bit [11:0] acc, input bit lk);
    bit [2:0]  op = ins[11:9];
    bit [11:0] pc1 = pc + 12'd1;
    bit [11:0] a0, ea, d, p;
    bit [12:0] s;
    ex_n = 0; x_acc = acc; x_link = lk; x_npc = pc1;
    if (op >= 3'd6) return;
    a0 = (ins[7] ? (pc1 & 12'o7600) : 12'o0) | {5'b0, ins[6:0]};
    ea = a0;
    if (ins[8]) begin
      p = exp_mem[a0];
      push(1'b0, a0, p);
      if (op <= 3'd3 && a0 >= 12'o10 && a0 <= 12'o17) begin
        ea = p + 12'd1;
        exp_mem[a0] = ea;
        push(1'b1, a0, ea);
      end else ea = p;
    end
    case (op)
      3'd0: begin d = exp_mem[ea]; push(1'b0, ea, d); x_acc = acc & d; end
      3'd1: begin
        d = exp_mem[ea]; push(1'b0, ea, d);
        s = {lk, acc} + {1'b0, d};
        x_acc = s[11:0]; x_link = s[12];
      end
      3'd2: begin
        d = exp_mem[ea]; push(1'b0, ea, d);
        d = d + 12'd1; exp_mem[ea] = d; push(1'b1, ea, d);
        if (d == 12'o0) x_npc = pc1 + 12'd1;
      end
      3'd3: begin exp_mem[ea] = acc; push(1'b1, ea, acc); x_acc = 12'o0; end
      3'd4: begin exp_mem[ea] = pc1; push(1'b1, ea, pc1); x_npc = ea + 12'd1; end
      default: x_npc = ea;
    endcase
  endtask

  function automatic string res_tag(input bit [2:0] op);
    case (op)
      3'd0: return "R6";
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd4, 3'd5: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic run_one(input bit [11:0] ins, input bit [11:0] pc,
                         input bit [11:0] acc, input bit lk);
    int wcnt = 0;
    bit [11:0] a0;
    string ctag;
    model(ins, pc, acc, lk);
    lg_n = 0;
    @(negedge clk);
    in_instr = ins; in_pc = pc; in_acc = acc; in_link = lk; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!done && wcnt < 400) begin @(negedge clk); wcnt++; end
    chk(done, "R12 completion", done, 1);
    chk(acc_out == x_acc, {res_tag(ins[11:9]), " acc"}, acc_out, x_acc);
    chk(link_out == x_link, {res_tag(ins[11:9]), " link"}, link_out, x_link);
    chk(next_pc == x_npc, {res_tag(ins[11:9]), " next_pc"}, next_pc, x_npc);
    chk(!in_ready, "R12 busy while done", in_ready, 0);
    a0 = {5'b0, ins[6:0]};
    if (ins[11:9] >= 3'd6) ctag = "R1 access count";
    else if ((ins[11:9] == 3'd4 || ins[11:9] == 3'd5) && ins[8] && !ins[7]
             && a0 >= 12'o10 && a0 <= 12'o17) ctag = "R5 access count";
    else ctag = "R11 access count";
    chk(lg_n == ex_n, ctag, lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      if (i == 0) ctag = ins[8] ? "R3 address" : "R2 address";
      else if (ins[8] && i == 1 && ex_w[1] && ex_a[1] == ex_a[0]) ctag = "R4 address";
      else ctag = "R11 address";
      chk(lg_a[i] == ex_a[i], ctag, lg_a[i], ex_a[i]);
      chk(lg_w[i] == ex_w[i], "R11 direction", lg_w[i], ex_w[i]);
      chk(lg_d[i] == ex_d[i], "R11 data", lg_d[i], ex_d[i]);
    end
    @(negedge clk);
    chk(!done, "R12 done pulse", done, 0);
  endtask

  initial begin
    bit [11:0] ins;
    int unused_seed;
    unused_seed = int'($urandom(32'd4711));
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 12'($urandom);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(in_ready && !done && !mem_req_valid, "R12 reset state",
        {in_ready, done, mem_req_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases
    mem[12'o20] = 12'o7777; exp_mem[12'o20] = 12'o7777;
    run_one(12'o1020, 12'o0100, 12'o0001, 1'b1);          // R7 double carry
    mem[12'o30] = 12'o7777; exp_mem[12'o30] = 12'o7777;
    run_one(12'o2030, 12'o0200, 12'o0000, 1'b0);          // R8 skip
    mem[12'o12] = 12'o7777; exp_mem[12'o12] = 12'o7777;
    run_one(12'o1412, 12'o0300, 12'o0005, 1'b0);          // R4 pointer wrap
    mem[12'o14] = 12'o0013; exp_mem[12'o14] = 12'o0013;
    run_one(12'o0414, 12'o0400, 12'o7777, 1'b0);          // R4 bump onto itself
    run_one(12'o5413, 12'o0500, 12'o0000, 1'b0);          // R5 JMP via window
    run_one(12'o4415, 12'o0600, 12'o0000, 1'b0);          // R5 JMS via window
    run_one(12'o4377, 12'o7777, 12'o0000, 1'b0);          // R12 PC wrap, R10
    run_one(12'o3245, 12'o1234, 12'o4321, 1'b1);          // R2 current page, R9
    run_one(12'o7200, 12'o0777, 12'o1111, 1'b1);          // R1
    run_one(12'o6001, 12'o7777, 12'o2222, 1'b0);          // R1 wrap
    run_one(12'o5377, 12'o7600, 12'o0000, 1'b0);          // R10 JMP current page

    // Random mix
    for (int n = 0; n < 300; n++) begin
      ins = 12'($urandom);
      if (($urandom % 4) == 0) ins = {ins[11:9], 2'b10, 4'b0001, ins[2:0]};
      run_one(ins, 12'($urandom), 12'($urandom), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule